// File: doc/BRIEF.md
# Programmable Chip Select Controller

This block drives the active-low chip-select strobes of an external memory bus on behalf of one bus master. The master presents an address, a direction and write data together with a request. The block compares the address against every channel's programmed window and picks the lowest-numbered channel that matches. It then runs the strobe sequence for that channel and returns a one-cycle acknowledge when the access is complete.

Each channel has a base word and an option word, both written and read through a 32-bit register port. The option word sets which address bits take part in the compare, which transfer direction the channel serves, how many wait states stretch the access, whether the strobe waits one cycle behind the address, and whether a write keeps the address and data on the bus for one cycle after the strobe releases. The timing fields are captured when an access starts, so a register write during an access affects only later accesses.

Top module: `chip_select_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all of `cs_n` is 1, `rw_n` is 1, `bus_ack` and `mem_drive` are 0, and every configuration word reads back as 0.
- R2: For channel n, the base word is at register address 0x40+8n and the option word is at 0x44+8n. The base word holds the compare address in bits 31:12 and the enable in bit 0. The option word holds the compare mask in bits 31:12, setup delay in bit 11, write hold in bit 10, wait states in bits 6:2, the served direction in bit 1 (1 = read) and the direction don't-care in bit 0. All other bits read 0. `reg_rdata` shows the word at `reg_addr` one cycle after the address is applied.
- R3: A channel matches only when its enable is 1 and bus address bits 31:12 equal its base bits wherever the mask bit is 1. Address bits whose mask bit is 0 are ignored.
- R4: When the don't-care bit is 0, a channel matches only accesses whose direction equals its direction bit. When the don't-care bit is 1, it matches both reads and writes.
- R5: When several channels match, only the lowest-numbered one asserts its strobe. At most one bit of `cs_n` is 0 at any time.
- R6: With setup delay 0, the winning strobe goes low in the cycle after the clock edge that samples the request. On a write, `rw_n` goes low in that same cycle.
- R7: With setup delay 1, the first cycle of the access drives the address with all strobes high and `rw_n` high. The strobe, and `rw_n` on a write, go low one cycle later.
- R8: The strobe stays low for WS+1 cycles, where WS is the wait-state field. `bus_ack` is high for exactly the last of those cycles.
- R9: On a write to a channel with write hold 1, `mem_drive`, `mem_addr` and `mem_wdata` stay valid for one cycle after the strobe and `rw_n` return high. Reads, and channels with write hold 0, get no extra cycle.
- R10: A request that matches no channel produces no strobe, no drive and no acknowledge.
- R11: If the request drops before the acknowledge cycle, the strobes, `rw_n` and `mem_drive` return to idle in the next cycle, and no acknowledge is produced.
- R12: `rw_n` stays high during reads. While `mem_drive` is 1, `mem_addr` holds the captured request address, and on writes `mem_wdata` holds the captured write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| bus_req | input | 1 | Master request, held until acknowledge |
| bus_write | input | 1 | Direction of the request, 1 = write |
| bus_addr | input | 32 | Request address |
| bus_wdata | input | 32 | Request write data |
| cs_n | output | NUM_CS | Active-low chip-select strobes |
| rw_n | output | 1 | Low during the strobe of a write |
| mem_addr | output | 32 | Address driven to memory |
| mem_wdata | output | 32 | Write data driven to memory |
| mem_drive | output | 1 | Address, data and attribute outputs valid |
| bus_ack | output | 1 | One-cycle transfer acknowledge |

## Verification
The bench builds the block with its default parameters: eight channels, an 8-bit register address and the register window at 0x40. The channels are programmed so that two windows nest, a read-only channel shadows a catch-all channel, one channel is disabled, and another compares only its top nibble. With this setup a single set of accesses reaches priority resolution, direction filtering, mask widths from 4 to 20 bits, and every timing path. Wait states up to 5, aborts in the setup cycle and in the middle of a stretched access, and the write-hold cycle are all compared cycle by cycle against expected strobe patterns built from queues.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int ADDR_W  = 32;
  localparam int MATCH_LSB = 12;
  localparam int MATCH_W = ADDR_W - MATCH_LSB;
  localparam int WS_W    = 5;

  localparam logic [31:0] BASE_KEEP = 32'hFFFF_F001;
  localparam logic [31:0] OPT_KEEP  = 32'hFFFF_FC7F;

  localparam int OPT_SETUP = 11;
  localparam int OPT_WHOLD = 10;
  localparam int OPT_WS_LO = 2;
  localparam int OPT_DIR   = 1;
  localparam int OPT_DCARE = 0;

  typedef struct packed {
    logic [MATCH_W-1:0] base;
    logic               en;
    logic [MATCH_W-1:0] mask;
    logic               dir_rd;
    logic               dcare;
    logic               setup;
    logic               whold;
    logic [WS_W-1:0]    ws;
  } chan_cfg_t;

  typedef struct packed {
    logic            setup;
    logic            whold;
    logic [WS_W-1:0] ws;
  } chan_tim_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_STRB  = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/csc_regs.sv
module csc_regs #(
  parameter int NCH      = 8,
  parameter int REG_AW   = 8,
  parameter int REG_BASE = 'h40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output csc_pkg::chan_cfg_t    cfg [NCH]
);
  import csc_pkg::*;

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [31:0]       base_q [NCH];
  logic [31:0]       opt_q  [NCH];
  logic [REG_AW-1:0] off;
  logic [REG_AW-1:0] off_hi;
  logic              in_win;
  logic [CH_W-1:0]   idx;
  logic [31:0]       rd_word;

  always_comb begin
    off    = reg_addr - REG_AW'(REG_BASE);
    off_hi = off >> 3;
    in_win = (reg_addr >= REG_AW'(REG_BASE)) && (off_hi < REG_AW'(NCH)) &&
             (off[1:0] == 2'b00);
    idx    = off_hi[CH_W-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[n] <= '0;
        opt_q[n]  <= '0;
      end else if (reg_wr && in_win && (idx == CH_W'(n))) begin
        if (off[2]) opt_q[n]  <= reg_wdata & OPT_KEEP;
        else        base_q[n] <= reg_wdata & BASE_KEEP;
      end
    end

    always_comb begin
      cfg[n].base   = base_q[n][31:MATCH_LSB];
      cfg[n].en     = base_q[n][0];
      cfg[n].mask   = opt_q[n][31:MATCH_LSB];
      cfg[n].setup  = opt_q[n][OPT_SETUP];
      cfg[n].whold  = opt_q[n][OPT_WHOLD];
      cfg[n].ws     = opt_q[n][OPT_WS_LO +: WS_W];
      cfg[n].dir_rd = opt_q[n][OPT_DIR];
      cfg[n].dcare  = opt_q[n][OPT_DCARE];
    end
  end

  always_comb begin
    rd_word = '0;
    if (in_win) rd_word = off[2] ? opt_q[idx] : base_q[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_word;
  end
endmodule

// File: rtl/csc_match.sv
module csc_match #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  csc_pkg::chan_cfg_t          cfg [NCH],
  input  logic [csc_pkg::MATCH_W-1:0] addr_hi,
  input  logic                        is_write,
  output logic                        hit,
  output logic [CH_W-1:0]             win_idx,
  output csc_pkg::chan_tim_t          win_tim
);
  import csc_pkg::*;

  logic [NCH-1:0] raw;

  for (genvar n = 0; n < NCH; n++) begin : g_cmp
    assign raw[n] = cfg[n].en &&
                    (((addr_hi ^ cfg[n].base) & cfg[n].mask) == '0) &&
                    (cfg[n].dcare || (cfg[n].dir_rd == !is_write));
  end

  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_tim = '0;
    for (int n = NCH - 1; n >= 0; n--) begin
      if (raw[n]) begin
        hit           = 1'b1;
        win_idx       = CH_W'(n);
        win_tim.setup = cfg[n].setup;
        win_tim.whold = cfg[n].whold;
        win_tim.ws    = cfg[n].ws;
      end
    end
  end
endmodule

// File: rtl/csc_seq.sv
module csc_seq #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_req,
  input  logic                     bus_write,
  input  logic [31:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic                     hit,
  input  logic [CH_W-1:0]          win_idx,
  input  csc_pkg::chan_tim_t       win_tim,
  output logic [NCH-1:0]           cs_n,
  output logic                     rw_n,
  output logic [31:0]              mem_addr,
  output logic [31:0]              mem_wdata,
  output logic                     mem_drive,
  output logic                     bus_ack
);
  import csc_pkg::*;

  seq_state_t      state;
  logic [WS_W-1:0] cnt;
  logic [CH_W-1:0] sel;
  logic            wr_q;
  logic            hold_q;

  function automatic logic [NCH-1:0] strobe_n(input logic [CH_W-1:0] i);
    return ~(NCH'(1) << i);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      sel       <= '0;
      wr_q      <= 1'b0;
      hold_q    <= 1'b0;
      cs_n      <= '1;
      rw_n      <= 1'b1;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_drive <= 1'b0;
      bus_ack   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cs_n      <= '1;
          rw_n      <= 1'b1;
          bus_ack   <= 1'b0;
          mem_drive <= 1'b0;
          if (bus_req && hit) begin
            mem_addr  <= bus_addr;
            mem_wdata <= bus_write ? bus_wdata : '0;
            mem_drive <= 1'b1;
            sel       <= win_idx;
            wr_q      <= bus_write;
            hold_q    <= bus_write && win_tim.whold;
            cnt       <= win_tim.ws;
            if (win_tim.setup) begin
              state <= SQ_SETUP;
            end else begin
              state   <= SQ_STRB;
              cs_n    <= strobe_n(win_idx);
              rw_n    <= !bus_write;
              bus_ack <= (win_tim.ws == '0);
            end
          end
        end
        SQ_SETUP: begin
          if (!bus_req) begin
            state     <= SQ_IDLE;
            mem_drive <= 1'b0;
          end else begin
            state   <= SQ_STRB;
            cs_n    <= strobe_n(sel);
            rw_n    <= !wr_q;
            bus_ack <= (cnt == '0);
          end
        end
        SQ_STRB: begin
          if (bus_ack) begin
            cs_n    <= '1;
            rw_n    <= 1'b1;
            bus_ack <= 1'b0;
            if (hold_q) begin
              state <= SQ_HOLD;
            end else begin
              state     <= SQ_IDLE;
              mem_drive <= 1'b0;
            end
          end else if (!bus_req) begin
            state     <= SQ_IDLE;
            cs_n      <= '1;
            rw_n      <= 1'b1;
            mem_drive <= 1'b0;
          end else begin
            cnt     <= cnt - 1'b1;
            bus_ack <= (cnt == WS_W'(1));
          end
        end
        default: begin
          state     <= SQ_IDLE;
          mem_drive <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/chip_select_ctrl.sv
module chip_select_ctrl #(
  parameter int NUM_CS   = 8,
  parameter int REG_AW   = 8,
  parameter int REG_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_req,
  input  logic              bus_write,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rw_n,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_drive,
  output logic              bus_ack
);
  import csc_pkg::*;

  localparam int CH_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  chan_cfg_t       cfg [NUM_CS];
  logic            hit;
  logic [CH_W-1:0] win_idx;
  chan_tim_t       win_tim;

  csc_regs #(.NCH(NUM_CS), .REG_AW(REG_AW), .REG_BASE(REG_BASE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  csc_match #(.NCH(NUM_CS), .CH_W(CH_W)) u_match (
    .cfg      (cfg),
    .addr_hi  (bus_addr[31:MATCH_LSB]),
    .is_write (bus_write),
    .hit      (hit),
    .win_idx  (win_idx),
    .win_tim  (win_tim)
  );

  csc_seq #(.NCH(NUM_CS), .CH_W(CH_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hit       (hit),
    .win_idx   (win_idx),
    .win_tim   (win_tim),
    .cs_n      (cs_n),
    .rw_n      (rw_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_drive (mem_drive),
    .bus_ack   (bus_ack)
  );
endmodule

// File: rtl/chip_select_ctrl_chk.sv
module chip_select_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_req,
  input logic [NCH-1:0] cs_n,
  input logic           rw_n,
  input logic           mem_drive,
  input logic           bus_ack
);
  localparam logic [NCH-1:0] NONE = '1;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cs_n == NONE && rw_n && !bus_ack && !mem_drive));

  assert_onehot_cs_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  assert_rw_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
    !rw_n |-> (cs_n != NONE));

  assert_ack_needs_cs_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (cs_n != NONE));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_cs_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_n != NONE) |-> mem_drive);

  assert_cs_needs_req_R11: assert property (@(posedge clk) disable iff (rst)
    (cs_n != NONE) |-> $past(bus_req));
endmodule

bind chip_select_ctrl chip_select_ctrl_chk #(.NCH(NUM_CS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .cs_n      (cs_n),
  .rw_n      (rw_n),
  .mem_drive (mem_drive),
  .bus_ack   (bus_ack)
);

// File: tb/tb_chip_select_ctrl.sv
`timescale 1ns/1ps
module tb_chip_select_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  cs_n;
  logic        rw_n;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_drive;
  logic        bus_ack;

  always #4 clk = ~clk;

  chip_select_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cs_n(cs_n), .rw_n(rw_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_drive(mem_drive), .bus_ack(bus_ack)
  );

  typedef struct {
    logic [7:0] csn;
    logic       rwn;
    logic       drv;
    logic       ack;
    string      tag;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          fails = 0;
  logic        mon_on = 1'b0;
  string       idle_tag = "R1";
  logic [31:0] cur_addr = '0;
  logic [31:0] cur_data = '0;
  logic        cur_wr = 1'b0;
  logic [31:0] sh_base [8];
  logic [31:0] sh_opt  [8];

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the queued expectation
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = '{csn: 8'hFF, rwn: 1'b1, drv: 1'b0, ack: 1'b0, tag: idle_tag};
      check(cs_n == e.csn, e.tag, "cs_n", 32'(cs_n), 32'(e.csn));
      check(rw_n == e.rwn, e.tag, "rw_n", 32'(rw_n), 32'(e.rwn));
      check(mem_drive == e.drv, e.tag, "mem_drive", 32'(mem_drive), 32'(e.drv));
      check(bus_ack == e.ack, e.tag, "bus_ack", 32'(bus_ack), 32'(e.ack));
      if (e.drv && mem_drive) begin
        check(mem_addr == cur_addr, "R12", "mem_addr", mem_addr, cur_addr);
        if (cur_wr) check(mem_wdata == cur_data, "R12", "mem_wdata", mem_wdata, cur_data);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    int idx;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    idx = (int'(a) - 'h40) >> 3;
    if (a[2]) sh_opt[idx] = d & 32'hFFFF_FC7F;
    else      sh_base[idx] = d & 32'hFFFF_F001;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #2;
    check(reg_rdata == exp, tag, "reg_rdata", reg_rdata, exp);
  endtask

  function automatic int exp_chan(input logic [31:0] a, input logic w);
    for (int n = 0; n < 8; n++) begin
      if (sh_base[n][0] &&
          (((a ^ sh_base[n]) & {sh_opt[n][31:12], 12'h000}) == 32'h0) &&
          (sh_opt[n][0] || (sh_opt[n][1] == !w)))
        return n;
    end
    return -1;
  endfunction

  // abort_at = 0: normal completion; otherwise request drops after that many cycles
  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input int abort_at, input string tag);
    exp_t seq[$];
    int   ch;
    ch = exp_chan(a, w);
    if (ch >= 0) begin
      logic [31:0] o;
      int ws;
      o  = sh_opt[ch];
      ws = int'(o[6:2]);
      if (o[11]) seq.push_back('{8'hFF, 1'b1, 1'b1, 1'b0, tag});
      for (int i = 0; i <= ws; i++)
        seq.push_back('{8'(~(8'd1 << ch)), !w, 1'b1, (i == ws), tag});
      if (w && o[10]) seq.push_back('{8'hFF, 1'b1, 1'b1, 1'b0, tag});
    end
    if (abort_at > 0)
      while (seq.size() > abort_at) void'(seq.pop_back());
    @(negedge clk);
    idle_tag = tag;
    cur_addr = a; cur_data = d; cur_wr = w;
    bus_addr = a; bus_write = w; bus_wdata = d; bus_req = 1'b1;
    foreach (seq[i]) exp_q.push_back(seq[i]);
    for (int c = 1; c < 200; c++) begin
      @(negedge clk);
      if (abort_at > 0) begin
        if (c == abort_at) begin bus_req = 1'b0; break; end
      end else if (ch < 0) begin
        if (c == 4) begin bus_req = 1'b0; break; end
      end else if (bus_ack) begin
        bus_req = 1'b0; break;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired R8 actual=hung expected=acknowledge");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) begin sh_base[n] = '0; sh_opt[n] = '0; end
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // R1: every configuration word reads zero after reset
    for (int n = 0; n < 8; n++) begin
      rd_check(8'(8'h40 + 8 * n), 32'h0, "R1");
      rd_check(8'(8'h44 + 8 * n), 32'h0, "R1");
    end
    // R2: field layout, unused bits read zero
    wr_reg(8'h50, 32'hFFFF_FFFF);
    wr_reg(8'h54, 32'hFFFF_FFFF);
    rd_check(8'h50, 32'hFFFF_F001, "R2");
    rd_check(8'h54, 32'hFFFF_FC7F, "R2");
    wr_reg(8'h50, 32'h0);
    wr_reg(8'h54, 32'h0);
    rd_check(8'h54, 32'h0, "R2");

    // Channel setup
    wr_reg(8'h40, 32'h1000_0001); wr_reg(8'h44, 32'hFFFF_0000 | (2 << 2) | 1);
    wr_reg(8'h48, 32'h1000_0001); wr_reg(8'h4C, 32'hFF00_0000 | (1 << 11) | (1 << 10) | 1);
    wr_reg(8'h58, 32'h2000_0001); wr_reg(8'h5C, 32'hFFFF_F000 | (1 << 2) | 2);
    wr_reg(8'h60, 32'h3000_0000); wr_reg(8'h64, 32'hFFFF_F000 | 1);
    wr_reg(8'h68, 32'h2000_0001); wr_reg(8'h6C, 32'hFFFF_F000 | (1 << 10) | 1);
    wr_reg(8'h78, 32'h4000_0001); wr_reg(8'h7C, 32'hF000_0000 | (5 << 2) | 1);
    rd_check(8'h7C, 32'hF000_0015, "R2");

    access(32'h1000_0010, 1'b0, 32'h0, 0, "R5");          // nested windows, ch0 wins
    access(32'h1000_1234, 1'b1, 32'hCAFE_0001, 0, "R6");  // write, no setup, 2 waits
    access(32'h1040_0000, 1'b0, 32'h0, 0, "R7");          // ch1 setup, read no hold
    access(32'h10FF_F000, 1'b1, 32'hA5A5_5A5A, 0, "R9");  // ch1 setup plus write hold
    access(32'h2000_0ABC, 1'b0, 32'h0, 0, "R4");          // read-only ch3 wins
    access(32'h2000_0ABC, 1'b1, 32'h1234_5678, 0, "R4");  // write falls to ch5, hold
    access(32'h3000_0000, 1'b1, 32'h0000_0001, 0, "R3");  // disabled channel
    access(32'h4ABC_0000, 1'b0, 32'h0, 0, "R8");          // ch7 nibble compare, 5 waits
    access(32'h5000_0000, 1'b0, 32'h0, 0, "R10");         // no match
    access(32'h4000_0000, 1'b0, 32'h0, 2, "R11");         // abort mid-wait
    access(32'h1040_0000, 1'b1, 32'h0BAD_0000, 1, "R11"); // abort in setup
    wr_reg(8'h60, 32'h3000_0001);
    access(32'h3000_0000, 1'b1, 32'h7777_0000, 0, "R3");  // now enabled, ch4
    access(32'h2000_0000, 1'b0, 32'h0, 0, "R12");

    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    check(exp_q.size() == 0, "R8", "expectations left", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule